// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single line. Once reception is enabled it hunts for a start bit and confirms it at the middle of the bit period. It then samples each data bit once, at the middle of its period, and assembles the bits into a received byte in the configured order. In nine-bit mode it also takes a ninth bit, which can be checked as a parity bit. A single stop bit is checked. All timing comes from an external enable pulse at sixteen times the baud rate. The system clock may be any multiple of that rate.

When a character completes, the block stores the byte and sets a ready flag. It also pulses an interrupt for one cycle and records parity, framing and overrun errors. Reading the data clears the ready flag. Reading the status clears the three error flags. A request-to-send output tells the far end whether the receive register can take another character.

Top module: `serial_rx_core`

## Requirements
- R1: With `cfg_flow_en`=1, `rts` is 0 exactly while `rx_en`=1 and `byte_ready`=0. In every other case `rts` is 1, including while `cfg_flow_en`=0 and at reset.
- R2: A start edge is accepted only if the line is still at the start level at the eighth oversample tick after the edge. A start pulse shorter than that produces no character, and the receiver returns to hunting.
- R3: With `cfg_msb_first`=0, the first data bit on the line lands in `rx_data[0]`. With `cfg_msb_first`=1, the first data bit lands in `rx_data[7]`.
- R4: With `cfg_nine`=1, a ninth bit follows the eight data bits and is presented on `rx_bit9`. With `cfg_nine`=0, `rx_bit9` reads 0.
- R5: When a character completes, `byte_ready` is set and `rx_irq` is high for exactly one cycle. `active` is 0 in that same cycle.
- R6: A one-cycle `data_rd` pulse clears `byte_ready`.
- R7: With `cfg_nine`=1 and `cfg_parity_en`=1, the ninth bit must equal the XOR of the eight data bits, XORed with `cfg_parity_odd`. A mismatch sets `parity_err`. A `status_rd` pulse clears it.
- R8: If the first stop bit is at the start level, `frame_err` is set and the byte is still delivered. A `status_rd` pulse clears `frame_err`.
- R9: If a character completes while `byte_ready` is still 1, the new byte replaces the old one and `overrun` is set. `overrun` stays set until a `status_rd` pulse.
- R10: With `cfg_start_high`=0, the start bit is 0 and the stop and idle level is 1. With `cfg_start_high`=1, both levels are inverted.
- R11: After reset, all flags, `rx_irq` and `active` are 0 and `rts` is 1. `active` rises while reception is enabled and the receiver is hunting or receiving.
- R12: While `rx_en`=0, `active` stays 0 and activity on the line produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| rx_en | input | 1 | Reception enable |
| cfg_nine | input | 1 | Nine-bit character mode |
| cfg_parity_en | input | 1 | Check the ninth bit as parity |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_msb_first | input | 1 | Data bit order on the line |
| cfg_start_high | input | 1 | Start bit level; the stop level is the opposite |
| cfg_flow_en | input | 1 | Enable request-to-send flow control |
| rxd | input | 1 | Serial input line |
| data_rd | input | 1 | Pulse: received data read |
| status_rd | input | 1 | Pulse: status read, clears the error flags |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| byte_ready | output | 1 | Unread byte present |
| rx_irq | output | 1 | One-cycle receive interrupt |
| active | output | 1 | Receiver hunting or receiving |
| parity_err | output | 1 | Parity mismatch seen |
| frame_err | output | 1 | Bad stop bit seen |
| overrun | output | 1 | Unread byte was overwritten |
| rts | output | 1 | Request to send, active low |

## Verification
The assertions check the following on every cycle:
- the interrupt is a single-cycle pulse that coincides with a set ready flag and an inactive receiver;
- a low `rts` never appears while a byte is waiting;
- the overrun flag holds until a status read, and a status read with no completing character clears the parity flag;
- a disabled receiver stays inactive.

Only the bench scenarios can show the rest:
- bit ordering and nine-bit assembly;
- rejection of a short start pulse;
- parity and stop-bit detection for both line polarities;
- byte replacement on overrun;
- the absence of any character while the receiver is disabled.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HUNT  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4,
    ST_DONE  = 3'd5
  } srx_state_e;

  function automatic logic parity_expected(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int CW    = $clog2(OVS),
  localparam int IW    = $clog2(DATA_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          start_high,
  input  logic          nine,
  output logic          active,
  output logic          bit_stb,
  output logic          bit_val,
  output logic [IW-1:0] bit_idx,
  output logic          done_stb,
  output logic          stop_ok
);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  srx_state_e    state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          sync1, sync2;
  logic          at_start;
  logic [IW-1:0] last_idx;

  assign at_start = (sync2 == start_high);
  assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      active   <= 1'b0;
      bit_stb  <= 1'b0;
      bit_val  <= 1'b0;
      bit_idx  <= '0;
      done_stb <= 1'b0;
      stop_ok  <= 1'b0;
    end else begin
      bit_stb  <= 1'b0;
      done_stb <= 1'b0;
      if (!rx_en) begin
        state  <= ST_IDLE;
        active <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_HUNT;
            active <= 1'b1;
          end
          ST_HUNT: begin
            if (tick && at_start) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (tick) begin
              if (cnt == MID) begin
                cnt   <= '0;
                idx   <= '0;
                state <= at_start ? ST_DATA : ST_HUNT;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (tick) begin
              if (cnt == LAST) begin
                cnt     <= '0;
                bit_stb <= 1'b1;
                bit_val <= sync2;
                bit_idx <= idx;
                if (idx == last_idx) state <= ST_STOP;
                else idx <= idx + 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_STOP: begin
            if (tick) begin
              if (cnt == LAST) begin
                cnt      <= '0;
                done_stb <= 1'b1;
                stop_ok  <= !at_start;
                state    <= ST_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DONE: begin
            active <= 1'b0;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_off_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!active && !done_stb));
endmodule

// File: rtl/srx_assemble.sv
module srx_assemble #(
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [IW-1:0]     bit_idx,
  input  logic              msb_first,
  output logic [DATA_W-1:0] data_q,
  output logic              ninth_q
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam logic [IW-1:0] POS_LSB = IW'(g);
    localparam logic [IW-1:0] POS_MSB = IW'(DATA_W - 1 - g);
    logic b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= 1'b0;
      else if (bit_stb && bit_idx == (msb_first ? POS_MSB : POS_LSB)) b_q <= bit_val;
    end
    assign data_q[g] = b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ninth_q <= 1'b0;
    else if (bit_stb && bit_idx == IW'(DATA_W)) ninth_q <= bit_val;
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_stb,
  input  logic              stop_ok,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ninth_in,
  input  logic              nine,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              data_rd,
  input  logic              status_rd,
  input  logic              flow_en,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              ready,
  output logic              irq,
  output logic              perr,
  output logic              ferr,
  output logic              ovr,
  output logic              rts
);
  logic par_bad;
  logic ready_d;

  assign par_bad = nine && par_en && (ninth_in != parity_expected(data_in[7:0], par_odd));
  assign ready_d = done_stb ? 1'b1 : (data_rd ? 1'b0 : ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      ready   <= 1'b0;
      irq     <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      ovr     <= 1'b0;
      rts     <= 1'b1;
    end else begin
      irq   <= done_stb;
      ready <= ready_d;
      rts   <= !(flow_en && rx_en && !ready_d);
      perr  <= (perr && !status_rd) || (done_stb && par_bad);
      ferr  <= (ferr && !status_rd) || (done_stb && !stop_ok);
      ovr   <= (ovr && !status_rd) || (done_stb && ready && !data_rd);
      if (done_stb) begin
        rx_data <= data_in;
        rx_bit9 <= nine && ninth_in;
      end
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_ready_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ready);
  assert_rts_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !rts |-> !ready);
  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr && !status_rd) |=> ovr);
  assert_perr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !done_stb) |=> !perr);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int IW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              cfg_nine,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_msb_first,
  input  logic              cfg_start_high,
  input  logic              cfg_flow_en,
  input  logic              rxd,
  input  logic              data_rd,
  input  logic              status_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              byte_ready,
  output logic              rx_irq,
  output logic              active,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun,
  output logic              rts
);
  logic          bit_stb, bit_val, done_stb, stop_ok, ninth_q;
  logic [IW-1:0] bit_idx;
  logic [DATA_W-1:0] data_q;

  srx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_sampler (
    .clk(clk), .rst(rst), .tick(tick16), .rx_en(rx_en), .rxd(rxd),
    .start_high(cfg_start_high), .nine(cfg_nine), .active(active),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_idx(bit_idx),
    .done_stb(done_stb), .stop_ok(stop_ok)
  );

  srx_assemble #(.DATA_W(DATA_W)) u_assemble (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_idx(bit_idx), .msb_first(cfg_msb_first),
    .data_q(data_q), .ninth_q(ninth_q)
  );

  srx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .done_stb(done_stb), .stop_ok(stop_ok),
    .data_in(data_q), .ninth_in(ninth_q), .nine(cfg_nine),
    .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
    .data_rd(data_rd), .status_rd(status_rd), .flow_en(cfg_flow_en),
    .rx_en(rx_en), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .ready(byte_ready), .irq(rx_irq), .perr(parity_err),
    .ferr(frame_err), .ovr(overrun), .rts(rts)
  );

  assert_irq_inactive_R5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !active);
endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rx_en = 1'b0, cfg_nine = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
  logic cfg_msb_first = 1'b0, cfg_start_high = 1'b0, cfg_flow_en = 1'b0;
  logic rxd = 1'b1, data_rd = 1'b0, status_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, byte_ready, rx_irq, active, parity_err, frame_err, overrun, rts;

  int checks = 0, failures = 0;
  int irq_cnt = 0, bad_irq = 0, cyc = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  serial_rx_core dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .cfg_nine(cfg_nine),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_msb_first(cfg_msb_first), .cfg_start_high(cfg_start_high),
    .cfg_flow_en(cfg_flow_en), .rxd(rxd), .data_rd(data_rd), .status_rd(status_rd),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .byte_ready(byte_ready), .rx_irq(rx_irq),
    .active(active), .parity_err(parity_err), .frame_err(frame_err),
    .overrun(overrun), .rts(rts)
  );

  // 16x enable: one clock in four
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  always @(negedge clk) begin
    cyc++;
    if (rx_irq) begin
      irq_cnt++;
      if (active || !byte_ready) bad_irq++;
    end
    if (cyc > 150000 && !done_flag) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_good);
    rxd = cfg_start_high;
    wait_clk(64);
    for (int i = 0; i < 8; i++) begin
      rxd = cfg_msb_first ? d[7 - i] : d[i];
      wait_clk(64);
    end
    if (cfg_nine) begin
      rxd = b9;
      wait_clk(64);
    end
    rxd = stop_good ? !cfg_start_high : cfg_start_high;
    wait_clk(64);
    rxd = !cfg_start_high;
    wait_clk(80);
  endtask

  task automatic pulse_data_rd();
    data_rd = 1'b1; wait_clk(1); data_rd = 1'b0; wait_clk(1);
  endtask

  task automatic pulse_status_rd();
    status_rd = 1'b1; wait_clk(1); status_rd = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    chk("R11 reset ready", byte_ready, 0);
    chk("R11 reset irq", rx_irq, 0);
    chk("R11 reset active", active, 0);
    chk("R11 reset errs", {parity_err, frame_err, overrun}, 0);
    chk("R11 reset rts", rts, 1);
  endtask

  task automatic t_lsb_first();
    int n0 = irq_cnt;
    rx_en = 1'b1; wait_clk(4);
    chk("R11 active when armed", active, 1);
    send_frame(8'hC5, 1'b0, 1'b1);
    chk("R3 lsb data", rx_data, 8'hC5);
    chk("R5 ready set", byte_ready, 1);
    chk("R5 one irq", irq_cnt - n0, 1);
    chk("R4 bit9 zero in 8-bit", rx_bit9, 0);
    chk("R8 no frame err", frame_err, 0);
    pulse_data_rd();
    chk("R6 ready cleared", byte_ready, 0);
  endtask

  task automatic t_msb_first();
    cfg_msb_first = 1'b1;
    send_frame(8'h2D, 1'b0, 1'b1);
    chk("R3 msb data", rx_data, 8'h2D);
    pulse_data_rd();
    cfg_msb_first = 1'b0;
  endtask

  task automatic t_nine_bit();
    cfg_nine = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b1);
    chk("R4 ninth bit", rx_bit9, 1);
    chk("R4 data", rx_data, 8'h5A);
    chk("R7 no parity check when disabled", parity_err, 0);
    pulse_data_rd();
  endtask

  task automatic t_parity();
    cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
    send_frame(8'h35, 1'b0, 1'b1);          // four ones: even parity bit 0
    chk("R7 even good", parity_err, 0);
    pulse_data_rd();
    send_frame(8'h35, 1'b1, 1'b1);
    chk("R7 even bad", parity_err, 1);
    pulse_status_rd();
    chk("R7 cleared by status read", parity_err, 0);
    pulse_data_rd();
    cfg_parity_odd = 1'b1;
    send_frame(8'h07, 1'b0, 1'b1);          // three ones: odd parity bit 0
    chk("R7 odd good", parity_err, 0);
    pulse_data_rd();
    cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0; cfg_nine = 1'b0;
  endtask

  task automatic t_framing();
    send_frame(8'h99, 1'b0, 1'b0);
    chk("R8 frame err", frame_err, 1);
    chk("R8 byte delivered", rx_data, 8'h99);
    pulse_status_rd();
    chk("R8 cleared by status read", frame_err, 0);
    pulse_data_rd();
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R9 overrun set", overrun, 1);
    chk("R9 new byte kept", rx_data, 8'h22);
    pulse_data_rd();
    chk("R9 overrun sticky", overrun, 1);
    pulse_status_rd();
    chk("R9 overrun cleared", overrun, 0);
  endtask

  task automatic t_glitch();
    int n0 = irq_cnt;
    rxd = cfg_start_high; wait_clk(16);
    rxd = !cfg_start_high; wait_clk(800);
    chk("R2 no char from short pulse", irq_cnt - n0, 0);
    chk("R2 no ready", byte_ready, 0);
    chk("R2 back to hunting", active, 1);
    send_frame(8'h3C, 1'b0, 1'b1);
    chk("R2 next frame received", rx_data, 8'h3C);
    pulse_data_rd();
  endtask

  task automatic t_inverted();
    rx_en = 1'b0;
    cfg_start_high = 1'b1; rxd = 1'b0;
    wait_clk(8);
    rx_en = 1'b1; wait_clk(8);
    send_frame(8'hA6, 1'b0, 1'b1);
    chk("R10 inverted data", rx_data, 8'hA6);
    chk("R10 inverted stop ok", frame_err, 0);
    pulse_data_rd();
    rx_en = 1'b0; cfg_start_high = 1'b0; rxd = 1'b1;
    wait_clk(8);
    rx_en = 1'b1; wait_clk(8);
  endtask

  task automatic t_flow();
    cfg_flow_en = 1'b1; wait_clk(3);
    chk("R1 rts low when empty", rts, 0);
    send_frame(8'h44, 1'b0, 1'b1);
    chk("R1 rts high when full", rts, 1);
    pulse_data_rd();
    chk("R1 rts low after read", rts, 0);
    rx_en = 1'b0; wait_clk(3);
    chk("R1 rts high when disabled", rts, 1);
    rx_en = 1'b1; cfg_flow_en = 1'b0; wait_clk(3);
    chk("R1 rts high without flow", rts, 1);
  endtask

  task automatic t_disabled();
    int n0 = irq_cnt;
    rx_en = 1'b0; wait_clk(3);
    send_frame(8'h81, 1'b0, 1'b1);
    chk("R12 active low", active, 0);
    chk("R12 no char", irq_cnt - n0, 0);
    chk("R12 no ready", byte_ready, 0);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_lsb_first();
    t_msb_first();
    t_nine_bit();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_inverted();
    t_flow();
    t_disabled();
    chk("R5 irq with ready and inactive", bad_irq, 0);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule